// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one core's private cache and keeps a single reservation on one cache line. A load-linked request records which line holds the target word. The block fetches that line in shared state, so taking out a reservation never takes the line away from another core and never breaks that core's reservation. A later store-conditional may write only while the reservation still stands. If anything takes the line out of this cache first, or if the core runs too many other operations before the store-conditional, the store-conditional fails and nothing is written.

Because the reserved line is only held shared, an eligible store-conditional first asks the coherence fabric for an upgrade to exclusive. While that upgrade is pending, the block stalls the core port. The write commits only if the grant arrives while the reservation is intact. When a snoop or eviction on the line and the grant land in the same cycle, the snoop wins. The pass or fail outcome is returned with a one-cycle strobe. Retrying is left to software.

Top module: `link_monitor`

## Requirements
- R1: A load-linked (`reqOp` = 2) records line `reqAddr >> log2(LINE_BYTES)` and sets the reservation. A store-conditional to any byte of that line is then eligible.
- R2: A store-conditional (`reqOp` = 3) with no reservation, or to a different line, fails. Its result (`scDone`=1, `scPass`=0) appears the cycle after it is accepted, with no upgrade request and no commit.
- R3: A snoop whose kind (`snoopKind`) is 1 (invalidate), 2 or 3 (ownership) on the reserved line clears the reservation, and so does an eviction of that line. A snoop of kind 0 (read) leaves the reservation in place, and so do snoops or evictions on other lines.
- R4: A load-linked never raises `upgReq`. `upgReq` rises only in the cycle after an eligible store-conditional is accepted, and `upgLine` then carries the reserved line.
- R5: While `upgReq` is high, `reqReady` is low. The cycle after `upgGrant` is seen, `scDone`=1, `scPass`=1 and `commitEn`=1, with `commitAddr` and `commitData` equal to the store-conditional's address and data.
- R6: A snoop of kind 1 to 3 or an eviction on the reserved line while the upgrade is pending fails the store-conditional with no commit. This also holds when it arrives in the same cycle as `upgGrant`.
- R7: After a load-linked, up to MAX_OPS loads (`reqOp` = 0) and stores (`reqOp` = 1) keep the reservation. The next such operation clears it. Each load-linked restarts the count.
- R8: A new load-linked replaces any earlier reservation. A store by this core to the reserved line leaves the reservation intact.
- R9: Every store-conditional clears the reservation when it completes, whether it passed or failed.
- R10: After reset, `reqReady`=1 and `upgReq`, `scDone`, `scPass` and `commitEn` are 0. `scPass` and `commitEn` are only ever high together with `scDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request valid |
| reqOp | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqData | input | DATA_W | Store-conditional write data |
| reqReady | output | 1 | Core port can accept a request |
| snoopValid | input | 1 | External request observed |
| snoopKind | input | 2 | 0 read, 1 invalidate, 2/3 ownership |
| snoopLine | input | LINE_W | Line address of the snoop |
| evictValid | input | 1 | A line is leaving this cache |
| evictLine | input | LINE_W | Line address being evicted |
| upgReq | output | 1 | Request to upgrade the reserved line to exclusive |
| upgLine | output | LINE_W | Line address for the upgrade |
| upgGrant | input | 1 | Upgrade granted |
| scDone | output | 1 | Store-conditional result strobe |
| scPass | output | 1 | Store-conditional succeeded |
| commitEn | output | 1 | Write the store-conditional data |
| commitAddr | output | ADDR_W | Address of the committed write |
| commitData | output | DATA_W | Data of the committed write |

## Verification
The bench builds the block with 16-bit addresses and data, 16-byte lines and an operation limit of 3. The small limit puts both sides of the expiry boundary within a few requests. The short line width makes same-line-different-word and neighbouring-line cases easy to construct. The bench holds its own model of the reservation, covering the line, validity and operation count, and derives every expected store-conditional outcome from that model. Directed cases cover the snoop-versus-grant collision and a stall of several cycles before the grant.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LINK  = 2'd2,
    OP_COND  = 2'd3
  } reqOp_e;

  localparam logic [1:0] SNOOP_READ = 2'd0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_UPG  = 1'b1
  } monState_e;

  typedef struct packed {
    logic linkSet;
    logic linkClr;
    logic cntInc;
    logic condCapture;
    logic resFire;
    logic resPass;
  } ctrlStrb_t;

endpackage

// File: rtl/link_mon_ctrl.sv
module link_mon_ctrl
  import link_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] reqOp,
  input  logic      linkValid,
  input  logic      reqHit,
  input  logic      killHit,
  input  logic      upgGrant,
  output logic      reqReady,
  output logic      upgReq,
  output ctrlStrb_t strb
);

  monState_e stateQ, stateD;
  reqOp_e    opCode;

  assign opCode   = reqOp_e'(reqOp);
  assign reqReady = (stateQ == ST_IDLE);
  assign upgReq   = (stateQ == ST_UPG);

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          unique case (opCode)
            OP_LINK:  strb.linkSet = 1'b1;
            OP_LOAD,
            OP_STORE: strb.cntInc = 1'b1;
            OP_COND: begin
              if (linkValid && reqHit && !killHit) begin
                strb.condCapture = 1'b1;
                stateD           = ST_UPG;
              end else begin
                strb.resFire = 1'b1;
                strb.linkClr = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_UPG: begin
        // a losing snoop or eviction outranks a grant in the same cycle
        if (killHit || !linkValid) begin
          strb.resFire = 1'b1;
          strb.linkClr = 1'b1;
          stateD       = ST_IDLE;
        end else if (upgGrant) begin
          strb.resFire = 1'b1;
          strb.resPass = 1'b1;
          strb.linkClr = 1'b1;
          stateD       = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/link_mon_dp.sv
module link_mon_dp
  import link_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LINE_W  = 26,
  parameter int MAX_OPS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              snoopValid,
  input  logic [1:0]        snoopKind,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  output logic              linkValid,
  output logic              reqHit,
  output logic              killHit,
  output logic [LINE_W-1:0] upgLine,
  output logic              scDone,
  output logic              scPass,
  output logic              commitEn,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData
);

  localparam int CNT_W = $clog2(MAX_OPS + 1);

  logic [LINE_W-1:0] linkLine;
  logic [LINE_W-1:0] reqLine;
  logic [CNT_W-1:0]  opCnt;
  logic [ADDR_W-1:0] condAddr;
  logic [DATA_W-1:0] condData;
  logic              snoopTake;
  logic              evictTake;

  assign reqLine   = reqAddr[ADDR_W-1 -: LINE_W];
  assign reqHit    = (reqLine == linkLine);
  assign snoopTake = snoopValid && (snoopKind != SNOOP_READ) && (snoopLine == linkLine);
  assign evictTake = evictValid && (evictLine == linkLine);
  assign killHit   = linkValid && (snoopTake || evictTake);
  assign upgLine   = linkLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkLine  <= '0;
      opCnt     <= '0;
    end else if (strb.linkSet) begin
      linkValid <= 1'b1;
      linkLine  <= reqLine;
      opCnt     <= '0;
    end else if (strb.linkClr || killHit) begin
      linkValid <= 1'b0;
    end else if (strb.cntInc) begin
      if (opCnt == CNT_W'(MAX_OPS)) linkValid <= 1'b0;
      else                          opCnt     <= opCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condAddr <= '0;
      condData <= '0;
    end else if (strb.condCapture) begin
      condAddr <= reqAddr;
      condData <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scDone   <= 1'b0;
      scPass   <= 1'b0;
      commitEn <= 1'b0;
    end else begin
      scDone   <= strb.resFire;
      scPass   <= strb.resFire && strb.resPass;
      commitEn <= strb.resFire && strb.resPass;
    end
  end

  assign commitAddr = condAddr;
  assign commitData = condData;

endmodule

// File: rtl/link_monitor.sv
module link_monitor
  import link_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OPS    = 16,
  localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  input  logic              snoopValid,
  input  logic [1:0]        snoopKind,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] evictLine,
  output logic              upgReq,
  output logic [LINE_W-1:0] upgLine,
  input  logic              upgGrant,
  output logic              scDone,
  output logic              scPass,
  output logic              commitEn,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData
);

  ctrlStrb_t strb;
  logic      linkValid;
  logic      reqHit;
  logic      killHit;

  link_mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .linkValid (linkValid),
    .reqHit    (reqHit),
    .killHit   (killHit),
    .upgGrant  (upgGrant),
    .reqReady  (reqReady),
    .upgReq    (upgReq),
    .strb      (strb)
  );

  link_mon_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LINE_W  (LINE_W),
    .MAX_OPS (MAX_OPS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .snoopValid (snoopValid),
    .snoopKind  (snoopKind),
    .snoopLine  (snoopLine),
    .evictValid (evictValid),
    .evictLine  (evictLine),
    .linkValid  (linkValid),
    .reqHit     (reqHit),
    .killHit    (killHit),
    .upgLine    (upgLine),
    .scDone     (scDone),
    .scPass     (scPass),
    .commitEn   (commitEn),
    .commitAddr (commitAddr),
    .commitData (commitData)
  );

endmodule

// File: rtl/link_monitor_chk.sv
module link_monitor_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic              reqReady,
  input logic              snoopValid,
  input logic [1:0]        snoopKind,
  input logic [LINE_W-1:0] snoopLine,
  input logic              evictValid,
  input logic [LINE_W-1:0] evictLine,
  input logic              upgReq,
  input logic [LINE_W-1:0] upgLine,
  input logic              upgGrant,
  input logic              scDone,
  input logic              scPass,
  input logic              commitEn
);

  logic lineLost;
  assign lineLost = (snoopValid && snoopKind != 2'd0 && snoopLine == upgLine) ||
                    (evictValid && evictLine == upgLine);

  a_r4_upg_after_cond: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upgReq) |-> $past(reqValid && reqReady && reqOp == 2'd3));

  a_r4_link_no_upg: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd2) |=> !upgReq);

  a_r5_stall_while_upg: assert property (@(posedge clk) disable iff (!rstN)
    upgReq |-> !reqReady);

  a_r5_commit_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> $past(upgReq && upgGrant));

  a_r6_loss_blocks_commit: assert property (@(posedge clk) disable iff (!rstN)
    (upgReq && lineLost) |=> !commitEn);

  a_r10_pass_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (scPass || commitEn) |-> scDone);

endmodule

bind link_monitor link_monitor_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (.*);

// File: tb/link_monitor_tb.sv
`timescale 1ns/1ps
module link_monitor_tb;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LB = 16;
  localparam int MO = 3;
  localparam int LW = AW - $clog2(LB);
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          reqReady;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopKind = '0;
  logic [LW-1:0] snoopLine = '0;
  logic          evictValid = 1'b0;
  logic [LW-1:0] evictLine = '0;
  logic          upgReq;
  logic [LW-1:0] upgLine;
  logic          upgGrant = 1'b0;
  logic          scDone, scPass, commitEn;
  logic [AW-1:0] commitAddr;
  logic [DW-1:0] commitData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the reservation
  bit            mValid = 0;
  logic [LW-1:0] mLine = '0;
  int            mCnt = 0;

  always #5 clk = ~clk;

  link_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB), .MAX_OPS(MO)) u_dut (.*);

  function automatic logic [LW-1:0] lineOf(logic [AW-1:0] a);
    return a[AW-1 -: LW];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (op == LL) begin mValid = 1; mLine = lineOf(a); mCnt = 0; end
    else if (op == LD || op == ST) begin
      if (mCnt == MO) mValid = 0; else mCnt++;
    end
  endtask

  task automatic snoop(logic [1:0] kind, logic [LW-1:0] ln);
    snoopValid = 1'b1; snoopKind = kind; snoopLine = ln;
    @(negedge clk);
    snoopValid = 1'b0;
    if (kind != 2'd0 && ln == mLine) mValid = 0;
  endtask

  task automatic evict(logic [LW-1:0] ln);
    evictValid = 1'b1; evictLine = ln;
    @(negedge clk);
    evictValid = 1'b0;
    if (ln == mLine) mValid = 0;
  endtask

  // store-conditional with outcome predicted from the model
  task automatic condStore(string tag, logic [AW-1:0] a, logic [DW-1:0] d, int stallCycles);
    bit expPass;
    expPass = mValid && (lineOf(a) == mLine);
    issue(SC, a, d);
    if (expPass) begin
      chk({tag, " R4 upgReq"}, upgReq, 1);
      chk({tag, " R4 upgLine"}, upgLine, lineOf(a));
      for (int i = 0; i < stallCycles; i++) begin
        @(negedge clk);
        chk({tag, " R5 ready low"}, reqReady, 0);
      end
      upgGrant = 1'b1;
      @(negedge clk);
      upgGrant = 1'b0;
      chk({tag, " R5 done"}, scDone, 1);
      chk({tag, " R5 pass"}, scPass, 1);
      chk({tag, " R5 commit"}, commitEn, 1);
      chk({tag, " R5 addr"}, commitAddr, a);
      chk({tag, " R5 data"}, commitData, d);
    end else begin
      chk({tag, " R2 done"}, scDone, 1);
      chk({tag, " R2 pass"}, scPass, 0);
      chk({tag, " R2 no commit"}, commitEn, 0);
      chk({tag, " R2 no upg"}, upgReq, 0);
    end
    mValid = 0;
    @(negedge clk);
    chk({tag, " R10 strobe single"}, scDone, 0);
  endtask

  task automatic tReset;
    chk("R10 ready", reqReady, 1);
    chk("R10 upg", upgReq, 0);
    chk("R10 done", scDone, 0);
    chk("R10 commit", commitEn, 0);
  endtask

  task automatic tBasic;
    issue(LL, 16'h1234, 0);
    chk("R4 no upg on link", upgReq, 0);
    condStore("R1 same line other word", 16'h123C, 16'hBEEF, 0);
  endtask

  task automatic tMismatch;
    condStore("R2 no link", 16'h2000, 16'h1111, 0);
    issue(LL, 16'h2000, 0);
    condStore("R2 other line", 16'h2010, 16'h2222, 0);
  endtask

  task automatic tSnoop;
    issue(LL, 16'h3000, 0);
    snoop(2'd0, lineOf(16'h3000));
    snoop(2'd2, lineOf(16'h3040));
    evict(lineOf(16'h3080));
    condStore("R3 read snoop keeps", 16'h3004, 16'h3333, 0);
    issue(LL, 16'h3000, 0);
    snoop(2'd1, lineOf(16'h3000));
    condStore("R3 invalidate clears", 16'h3004, 16'h3334, 0);
    issue(LL, 16'h3000, 0);
    snoop(2'd3, lineOf(16'h3000));
    condStore("R3 ownership clears", 16'h3004, 16'h3335, 0);
    issue(LL, 16'h3000, 0);
    evict(lineOf(16'h3000));
    condStore("R3 evict clears", 16'h3004, 16'h3336, 0);
  endtask

  task automatic tCollide;
    issue(LL, 16'h4000, 0);
    issue(SC, 16'h4008, 16'h4444);
    chk("R6 upg pending", upgReq, 1);
    upgGrant = 1'b1; snoopValid = 1'b1; snoopKind = 2'd2; snoopLine = lineOf(16'h4000);
    @(negedge clk);
    upgGrant = 1'b0; snoopValid = 1'b0; mValid = 0;
    chk("R6 done", scDone, 1);
    chk("R6 snoop wins pass", scPass, 0);
    chk("R6 snoop wins commit", commitEn, 0);
    chk("R6 ready back", reqReady, 1);
    issue(LL, 16'h4100, 0);
    issue(SC, 16'h4100, 16'h4545);
    evictValid = 1'b1; evictLine = lineOf(16'h4100);
    @(negedge clk);
    evictValid = 1'b0; mValid = 0;
    chk("R6 evict while pending", scDone, 1);
    chk("R6 evict no commit", commitEn, 0);
    @(negedge clk);
  endtask

  task automatic tStall;
    issue(LL, 16'h5000, 0);
    condStore("R5 stalled grant", 16'h5002, 16'h5555, 3);
  endtask

  task automatic tLimit;
    issue(LL, 16'h6000, 0);
    for (int i = 0; i < MO; i++) issue(LD, 16'h7000 + 16'(i * 16), 0);
    chk("R7 model keeps at limit", 32'(mValid), 1);
    condStore("R7 at limit", 16'h6004, 16'h6666, 0);
    issue(LL, 16'h6000, 0);
    for (int i = 0; i <= MO; i++) issue(ST, 16'h7000, 0);
    chk("R7 model clears past limit", 32'(mValid), 0);
    condStore("R7 past limit", 16'h6004, 16'h6667, 0);
    issue(LL, 16'h6000, 0);
    issue(LD, 16'h7000, 0);
    issue(LD, 16'h7000, 0);
    issue(LL, 16'h6000, 0);
    for (int i = 0; i < MO; i++) issue(LD, 16'h7000, 0);
    condStore("R7 count restarts", 16'h6004, 16'h6668, 0);
  endtask

  task automatic tReplace;
    issue(LL, 16'h8000, 0);
    issue(LL, 16'h9000, 0);
    condStore("R8 old line replaced", 16'h8000, 16'h8888, 0);
    issue(LL, 16'h8000, 0);
    issue(LL, 16'h9000, 0);
    condStore("R8 new line linked", 16'h9006, 16'h9999, 0);
    issue(LL, 16'hA000, 0);
    issue(ST, 16'hA004, 0);
    condStore("R8 own store keeps", 16'hA008, 16'hAAAA, 0);
  endtask

  task automatic tClear;
    issue(LL, 16'hB000, 0);
    condStore("R9 first pass", 16'hB000, 16'hB0B0, 0);
    condStore("R9 after pass", 16'hB000, 16'hB1B1, 0);
    issue(LL, 16'hB000, 0);
    condStore("R9 mismatch fails", 16'hC000, 16'hC0C0, 0);
    condStore("R9 after fail", 16'hB000, 16'hB2B2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tMismatch();
    tSnoop();
    tCollide();
    tStall();
    tLimit();
    tReplace();
    tClear();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule